// File: doc/BRIEF.md
# JTAG Test Access Port with Debug Access Register

This block is the boundary-scan entry point of a debug interface. A probe drives the four standard serial pins (test clock, mode select, data in and an optional test reset). The block walks the sixteen-state test controller, holds a 4-bit instruction and routes the serial data path through one of three data registers: a single-bit bypass stage, a 32-bit identification word and a 35-bit debug access register.

The access register lets the probe reach the debug-port registers that lie outside this block. A value shifted into it packs a read/write flag, a two-bit register address and a 32-bit write word. At Update-DR the block presents these on a parallel request interface for exactly one test-clock cycle. The downstream logic keeps a response word and a 3-bit acknowledge on the response inputs. The next Capture-DR of the access register loads them, so the following scan returns the result of the previous request.

All logic runs on the test clock. Test reset is synchronous and active high. Serial output changes only on falling test-clock edges.

Top module: `dbg_tap`

## Requirements
- R1: While `trst` is high at a rising `tck` edge the controller goes to Test-Logic-Reset, `tdo` and `tdo_oe` are 0 and `req_valid` is 0. After release the controller follows the standard sixteen-state sequence on `tms`, sampled at rising `tck`.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R3: In Test-Logic-Reset the instruction becomes 4'b1110, which selects the identification register. A data scan of that register returns 32'h4BA00477, least significant bit first.
- R4: Capture-IR loads 4'b0001 into the instruction shifter. Instruction scans shift LSB first from `tdi` to `tdo`, and Update-IR makes the shifted value the active instruction.
- R5: Instruction 4'b1111, and every code other than 4'b1110 and 4'b1010, selects a 1-bit bypass stage that captures 0. During a data scan `tdo` therefore repeats `tdi` one cycle later, after a leading 0.
- R6: Instruction 4'b1010 selects the 35-bit access register. Of the shifted-in value, bit 0 is the read flag (`req_rnw`, 1 = read, 0 = write), bits 2:1 are `req_addr` and bits 34:3 are `req_wdata`. Update-DR raises `req_valid` for exactly one cycle with these fields.
- R7: Capture-DR with the access register selected loads `rsp_rdata` into bits 34:3 and `rsp_ack` into bits 2:0, and these are shifted out LSB first. Acknowledge codes (3'b010 OK/FAULT, 3'b001 WAIT, others reserved) pass through unchanged.
- R8: `tdo` changes only on falling `tck` edges. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 otherwise.
- R9: `req_valid` is raised only after an Update-DR with the access register selected. Update-IR and updates of the other data registers produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Test reset, synchronous, active high |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | High while tdo carries shift data |
| req_valid | output | 1 | One-cycle access request strobe |
| req_rnw | output | 1 | Request is a read (1) or a write (0) |
| req_addr | output | 2 | Debug-port register address |
| req_wdata | output | 32 | Write data of the request |
| rsp_rdata | input | 32 | Read data returned by the debug port |
| rsp_ack | input | 3 | Acknowledge code returned by the debug port |

## Verification
The assertions assume that `trst` is held high for at least one rising edge before activity starts, and that `tms` and `tdi` are stable around every rising `tck` edge. The bench changes its inputs one nanosecond after each rising edge and raises reset across several edges at start-up and once in mid-operation. The response inputs are assumed steady across each Capture-DR. The bench writes them only while the controller idles in Run-Test/Idle between scans.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
    tap_state_e nxt;
    case (cur)
      ST_TLR:    nxt = m ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = m ? ST_UPD_IR : ST_SH_IR;
      default:   nxt = m ? ST_SEL_DR : ST_RTI;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck) begin
    if (trst) state <= ST_TLR;
    else      state <= tap_next(state, tms);
  end

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
  import dbg_tap_pkg::*;
#(
  parameter int              IR_W    = 4,
  parameter logic [IR_W-1:0] OP_ID   = 4'b1110,
  parameter logic [IR_W-1:0] CAP_PAT = 4'b0001
) (
  input  logic            tck,
  input  logic            trst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck) begin
    if (trst) begin
      ir_sr <= CAP_PAT;
      ir    <= OP_ID;
    end else begin
      case (state)
        ST_TLR:    ir    <= OP_ID;
        ST_CAP_IR: ir_sr <= CAP_PAT;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir    <= ir_sr;
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
  import dbg_tap_pkg::*;
#(
  parameter int              IR_W     = 4,
  parameter logic [IR_W-1:0] OP_ID    = 4'b1110,
  parameter logic [IR_W-1:0] OP_ACC   = 4'b1010,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4BA00477,
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 2,
  parameter int              ACK_W    = 3
) (
  input  logic              tck,
  input  logic              trst,
  input  tap_state_e        state,
  input  logic [IR_W-1:0]   ir,
  input  logic              tdi,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic [ACK_W-1:0]  rsp_ack,
  output logic              dr_lsb,
  output logic              req_valid,
  output logic              req_rnw,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata
);

  localparam int ACC_W = DATA_W + ADDR_W + 1;

  logic             byp_q;
  logic [ID_W-1:0]  id_sr;
  logic [ACC_W-1:0] acc_sr;
  logic             sel_id, sel_acc;

  assign sel_id  = (ir == OP_ID);
  assign sel_acc = (ir == OP_ACC);

  always_ff @(posedge tck) begin
    if (trst) begin
      byp_q     <= 1'b0;
      id_sr     <= '0;
      acc_sr    <= '0;
      req_valid <= 1'b0;
      req_rnw   <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      req_valid <= 1'b0;
      case (state)
        ST_CAP_DR: begin
          if (sel_acc)     acc_sr <= ACC_W'({rsp_rdata, rsp_ack});
          else if (sel_id) id_sr  <= ID_VALUE;
          else             byp_q  <= 1'b0;
        end
        ST_SH_DR: begin
          if (sel_acc)     acc_sr <= {tdi, acc_sr[ACC_W-1:1]};
          else if (sel_id) id_sr  <= {tdi, id_sr[ID_W-1:1]};
          else             byp_q  <= tdi;
        end
        ST_UPD_DR: begin
          if (sel_acc) begin
            req_valid <= 1'b1;
            req_rnw   <= acc_sr[0];
            req_addr  <= acc_sr[ADDR_W:1];
            req_wdata <= acc_sr[ACC_W-1:ADDR_W+1];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (sel_acc)     dr_lsb = acc_sr[0];
    else if (sel_id) dr_lsb = id_sr[0];
    else             dr_lsb = byp_q;
  end

endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
  import dbg_tap_pkg::*;
#(
  parameter int              IR_W     = 4,
  parameter logic [IR_W-1:0] OP_ID    = 4'b1110,
  parameter logic [IR_W-1:0] OP_ACC   = 4'b1010,
  parameter logic [IR_W-1:0] IR_CAP   = 4'b0001,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4BA00477,
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 2,
  parameter int              ACK_W    = 3
) (
  input  logic              tck,
  input  logic              trst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              req_valid,
  output logic              req_rnw,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic [ACK_W-1:0]  rsp_ack
);

  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  logic            shifting, shift_bit;

  dbg_tap_fsm fsm_i (
    .tck(tck), .trst(trst), .tms(tms), .state(tap_state)
  );

  dbg_tap_ir #(.IR_W(IR_W), .OP_ID(OP_ID), .CAP_PAT(IR_CAP)) ir_i (
    .tck(tck), .trst(trst), .state(tap_state), .tdi(tdi),
    .ir(ir_q), .ir_lsb(ir_lsb)
  );

  dbg_tap_dr #(
    .IR_W(IR_W), .OP_ID(OP_ID), .OP_ACC(OP_ACC), .ID_W(ID_W),
    .ID_VALUE(ID_VALUE), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACK_W(ACK_W)
  ) dr_i (
    .tck(tck), .trst(trst), .state(tap_state), .ir(ir_q), .tdi(tdi),
    .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack), .dr_lsb(dr_lsb),
    .req_valid(req_valid), .req_rnw(req_rnw), .req_addr(req_addr),
    .req_wdata(req_wdata)
  );

  assign shifting  = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
  assign shift_bit = (tap_state == ST_SH_IR) ? ir_lsb : dr_lsb;

  // Serial output is retimed to the falling edge so the probe samples a settled bit.
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= shifting ? shift_bit : 1'b0;
      tdo_oe <= shifting;
    end
  end

endmodule

// File: rtl/dbg_tap_chk.sv
module dbg_tap_chk
  import dbg_tap_pkg::*;
#(
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] OP_ID  = 4'b1110,
  parameter logic [IR_W-1:0] OP_ACC = 4'b1010
) (
  input logic            tck,
  input logic            trst,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir,
  input logic            req_valid,
  input logic            tdo_oe
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (trst)             ones_cnt <= '0;
    else if (!tms)        ones_cnt <= '0;
    else if (ones_cnt < 5) ones_cnt <= ones_cnt + 3'd1;
  end

  assert_tms_reset_R2: assert property (@(posedge tck) disable iff (trst)
    (ones_cnt >= 3'd5) |-> (state == ST_TLR));

  assert_ir_default_R3: assert property (@(posedge tck) disable iff (trst)
    (state == ST_TLR) |=> (ir == OP_ID));

  assert_req_one_cycle_R6: assert property (@(posedge tck) disable iff (trst)
    req_valid |=> !req_valid);

  assert_oe_window_R8: assert property (@(posedge tck) disable iff (trst)
    tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

  assert_req_source_R9: assert property (@(posedge tck) disable iff (trst)
    req_valid |-> $past(state == ST_UPD_DR && ir == OP_ACC));

endmodule

bind dbg_tap dbg_tap_chk #(.IR_W(IR_W), .OP_ID(OP_ID), .OP_ACC(OP_ACC)) chk_i (
  .tck(tck), .trst(trst), .tms(tms), .state(tap_state), .ir(ir_q),
  .req_valid(req_valid), .tdo_oe(tdo_oe)
);

// File: tb/dbg_tap_tb_top.sv
module dbg_tap_tb_top;

  logic        tck = 1'b0;
  logic        trst = 1'b1;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic [2:0]  rsp_ack = '0;
  logic        tdo, tdo_oe, req_valid, req_rnw;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;

  always #10 tck = ~tck;

  dbg_tap dut_i (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .req_valid(req_valid), .req_rnw(req_rnw), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic oe_smp;

  typedef struct packed { logic rnw; logic [1:0] addr; logic [31:0] wdata; } req_t;
  req_t exp_q[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One test-clock cycle: inputs set after the rising edge, tdo sampled after the falling edge.
  task automatic cyc(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    @(negedge tck); #2;
    o = tdo;
    oe_smp = tdo_oe;
    @(posedge tck); #1;
    chk("R8 tdo held across rising edge", {63'd0, tdo}, {63'd0, o});
  endtask

  // Starts and ends in Run-Test/Idle.
  task automatic scan(input bit is_ir, input int w, input logic [63:0] din,
                      output logic [63:0] dout);
    logic o;
    cyc(1'b1, 1'b0, o);
    if (is_ir) cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    chk("R8 oe low in capture", {63'd0, oe_smp}, 64'd0);
    dout = '0;
    for (int i = 0; i < w; i++) begin
      cyc(i == w - 1, din[i], o);
      dout[i] = o;
      if (i == 0 || i == w - 1) chk("R8 oe high in shift", {63'd0, oe_smp}, 64'd1);
    end
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
  endtask

  // Scoreboard monitor: every request strobe must match the next queued expectation.
  always @(negedge tck) begin
    if (!trst && req_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9: unexpected request actual=%h expected=none",
                 {req_rnw, req_addr, req_wdata});
      end else begin
        req_t e;
        e = exp_q.pop_front();
        chk("R6 request fields", {29'd0, req_rnw, req_addr, req_wdata}, {29'd0, e});
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] dout;
    logic o;
    req_t r;

    repeat (3) @(posedge tck);
    #2;
    chk("R1 reset tdo_oe", {63'd0, tdo_oe}, 64'd0);
    chk("R1 reset tdo", {63'd0, tdo}, 64'd0);
    chk("R1 reset req_valid", {63'd0, req_valid}, 64'd0);
    @(posedge tck); #1;
    trst = 1'b0;
    cyc(1'b0, 1'b0, o);

    // R3: default instruction reads the identification word
    scan(1'b0, 32, 64'h0, dout);
    chk("R3 id word", dout, 64'h4BA00477);

    // R4: instruction capture pattern, then select access register
    scan(1'b1, 4, 64'hA, dout);
    chk("R4 ir capture", dout, 64'h1);

    // R6/R7: write request, response OK
    rsp_rdata = 32'hDEADBEEF;
    rsp_ack   = 3'b010;
    r = '{rnw: 1'b0, addr: 2'b10, wdata: 32'h12345678};
    exp_q.push_back(r);
    scan(1'b0, 35, {29'd0, r.wdata, r.addr, r.rnw}, dout);
    chk("R7 capture OK ack", dout, {29'd0, 32'hDEADBEEF, 3'b010});

    // R6/R7: read request, response WAIT
    rsp_rdata = 32'hCAFEF00D;
    rsp_ack   = 3'b001;
    r = '{rnw: 1'b1, addr: 2'b01, wdata: 32'h0};
    exp_q.push_back(r);
    scan(1'b0, 35, {29'd0, r.wdata, r.addr, r.rnw}, dout);
    chk("R7 capture WAIT ack", dout, {29'd0, 32'hCAFEF00D, 3'b001});

    // R7: reserved acknowledge passes unchanged
    rsp_rdata = 32'h00000000;
    rsp_ack   = 3'b111;
    r = '{rnw: 1'b0, addr: 2'b11, wdata: 32'hA5A5A5A5};
    exp_q.push_back(r);
    scan(1'b0, 35, {29'd0, r.wdata, r.addr, r.rnw}, dout);
    chk("R7 capture reserved ack", dout, {29'd0, 32'h0, 3'b111});
    chk("R6 all requests seen", 64'(exp_q.size()), 64'd0);

    // R5: explicit bypass opcode
    scan(1'b1, 4, 64'hF, dout);
    chk("R4 ir capture again", dout, 64'h1);
    scan(1'b0, 8, 64'hB6, dout);
    chk("R5 bypass delay", dout, {56'd0, 8'h6C});

    // R5: unused opcode falls back to bypass
    scan(1'b1, 4, 64'h3, dout);
    scan(1'b0, 8, 64'h5B, dout);
    chk("R5 unused opcode bypass", dout, {56'd0, 8'hB6});

    // R2: five high tms from Shift-DR reach Test-Logic-Reset
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, o);
    cyc(1'b0, 1'b0, o);
    chk("R8 oe low in idle", {63'd0, oe_smp}, 64'd0);
    scan(1'b0, 32, 64'h0, dout);
    chk("R2 id after tms reset", dout, 64'h4BA00477);

    // R1: reset in the middle of an instruction scan
    scan(1'b1, 4, 64'hA, dout);
    cyc(1'b1, 1'b0, o);
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    trst = 1'b1;
    cyc(1'b0, 1'b1, o);
    cyc(1'b0, 1'b1, o);
    #2;
    chk("R1 oe cleared by reset", {63'd0, tdo_oe}, 64'd0);
    trst = 1'b0;
    cyc(1'b0, 1'b0, o);
    scan(1'b0, 32, 64'hFFFF, dout);
    chk("R1 id after trst", dout, 64'h4BA00477);
    chk("R9 no stray requests", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule